// File: doc/BRIEF.md
# Dimming Level to Current Target Converter

This block takes the stream of digitized voltage samples from a shared dimming pin and turns it into the output-current target used by a constant-current regulation loop. Each sample is smoothed by a first-order low-pass filter. The filtered level then goes through a transfer curve. Below a programmable lower knee the curve gives a programmable minimum current. At or above a fixed upper knee it gives the full set current. Between the two knees it interpolates, either linearly or with a square law.

An optional dim-to-off function drives the target to zero when the filtered level falls under an "off" level. The target stays at zero until the level climbs above a separate, higher "on" level, so the output does not chatter near the edge.

The same pin also serves as a serial configuration port. When it is driven above a configuration level, the block stops dimming and holds full current. It stays in that state until reset, so that serial traffic on the pin is never read as a dimming request.

Top module: `dimproc_top`

## Requirements
- R1: After reset the target is 0, the off flag is 0 and the serial-mode flag is 0. The target stays 0 until the first valid sample arrives.
- R2: The first valid sample after reset loads the filter directly. Each later sample updates a 16-bit accumulator as acc = acc + x - (acc >> 4). The filtered level is acc >> 4.
- R3: When the filtered level is at or above the upper knee HI_LEVEL (default code 2818), the target equals cfg_imax.
- R4: When the filtered level is at or below cfg_lo_level (and under HI_LEVEL), the target equals cfg_imin.
- R5: With cfg_quad = 0 and the level strictly between the knees, the target is imin + ((imax - imin) * n) >> 12, where n = ((level - lo) << 12) / (HI_LEVEL - lo), truncated.
- R6: With cfg_quad = 1 and the level strictly between the knees, the target is imin + ((imax - imin) * ((n * n) >> 12)) >> 12, with n as in R5, all truncated.
- R7: With cfg_dto_en = 1 and the block not off, a filtered level strictly below cfg_off_level sets the off flag. While the flag is set, the target is 0.
- R8: Once off, the block stays off while the filtered level is at or below cfg_on_level. It turns back on only when the level is strictly above cfg_on_level.
- R9: With cfg_dto_en = 0 the off flag is cleared, and the curve output drives the target whatever the level is.
- R10: The serial-mode flag sets only after 4 consecutive valid raw samples strictly above UART_LEVEL (default code 3604). Any valid sample at or below that level restarts the count.
- R11: Once set, the serial-mode flag stays set until reset. The target then equals cfg_imax and the off flag is 0, whatever the later samples or dim-to-off settings are.
- R12: The target and the off flag are registered. They reflect a sample from the second rising clock edge after the edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | ADC_W | Raw pin level code |
| cfg_lo_level | input | ADC_W | Lower knee level |
| cfg_imin | input | CUR_W | Minimum dimmed current code |
| cfg_imax | input | CUR_W | Full set current code |
| cfg_quad | input | 1 | Curve select: 0 linear, 1 square law |
| cfg_dto_en | input | 1 | Dim-to-off enable |
| cfg_off_level | input | ADC_W | Level under which output turns off |
| cfg_on_level | input | ADC_W | Level over which output turns back on |
| target_o | output | CUR_W | Current target code |
| off_o | output | 1 | Dim-to-off active |
| uart_o | output | 1 | Serial configuration mode latched |

## Verification
The curve is driven with levels below the lower knee, exactly at the upper knee, above it, and at the midpoint of the span. The midpoint is run once with each curve shape; there the linear and square-law results differ (2100 against 1150), which shows that the curve select is decoded. A ramp of repeated samples walks the filtered level down through the off level and then up past the on level. The walk shows that a level lying between the two thresholds keeps the previous state. The serial detector first gets a run of three high samples broken by a low one, which must not latch, and then four consecutive high samples, which must latch. Low samples and dim-to-off settings applied afterwards confirm the latch holds.

// File: rtl/dimproc_pkg.sv
package dimproc_pkg;

    localparam int DEF_ADC_W      = 12;
    localparam int DEF_CUR_W      = 12;
    localparam int DEF_FILT_SHIFT = 4;
    localparam int DEF_HI_LEVEL   = 2818;
    localparam int DEF_UART_LEVEL = 3604;
    localparam int DEF_UART_RUN   = 4;

    typedef enum logic {
        CURVE_LIN  = 1'b0,
        CURVE_QUAD = 1'b1
    } curve_e;

    typedef enum logic {
        OUT_ON  = 1'b0,
        OUT_OFF = 1'b1
    } out_state_e;

    function automatic int clog2_min1(input int v);
        int r;
        r = 1;
        while ((1 << r) < v) r++;
        return r;
    endfunction

endpackage

// File: rtl/dim_filter.sv
module dim_filter
    import dimproc_pkg::*;
#(
    parameter int ADC_W = DEF_ADC_W,
    parameter int SHIFT = DEF_FILT_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [ADC_W-1:0] in_code,
    output logic [ADC_W-1:0] filt_q,
    output logic             primed_q
);
    localparam int ACC_W = ADC_W + SHIFT;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   acc_sum;

    always_comb begin
        acc_sum = {1'b0, acc_q} + {{(SHIFT+1){1'b0}}, in_code}
                - {{(SHIFT+1){1'b0}}, acc_q[ACC_W-1:SHIFT]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            primed_q <= 1'b0;
        end else if (in_valid) begin
            primed_q <= 1'b1;
            if (!primed_q) acc_q <= {in_code, {SHIFT{1'b0}}};
            else           acc_q <= acc_sum[ACC_W-1:0];
        end
    end

    assign filt_q = acc_q[ACC_W-1:SHIFT];

    assert_first_load_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !primed_q) |=> (filt_q == $past(in_code)));

endmodule

// File: rtl/dim_uart_detect.sv
module dim_uart_detect
    import dimproc_pkg::*;
#(
    parameter int ADC_W      = DEF_ADC_W,
    parameter int UART_LEVEL = DEF_UART_LEVEL,
    parameter int UART_RUN   = DEF_UART_RUN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [ADC_W-1:0] in_code,
    output logic             uart_q
);
    localparam int CNT_W = clog2_min1(UART_RUN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UART_RUN - 1);
    localparam logic [ADC_W-1:0] THR  = ADC_W'(UART_LEVEL);

    logic [CNT_W-1:0] run_q;
    logic             high;

    assign high = (in_code > THR);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            uart_q <= 1'b0;
        end else if (in_valid) begin
            if (!high) begin
                run_q <= '0;
            end else if (run_q == LAST) begin
                uart_q <= 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        uart_q |=> uart_q);

    assert_rise_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(uart_q) |-> $past(in_valid && (in_code > THR)));

endmodule

// File: rtl/dim_curve.sv
module dim_curve
    import dimproc_pkg::*;
#(
    parameter int ADC_W    = DEF_ADC_W,
    parameter int CUR_W    = DEF_CUR_W,
    parameter int HI_LEVEL = DEF_HI_LEVEL
) (
    input  logic [ADC_W-1:0] level,
    input  logic [ADC_W-1:0] lo_level,
    input  logic [CUR_W-1:0] imin,
    input  logic [CUR_W-1:0] imax,
    input  curve_e           shape,
    output logic [CUR_W-1:0] target
);
    localparam int F  = ADC_W;
    localparam int W2 = 2 * ADC_W;
    localparam int PW = CUR_W + ADC_W;
    localparam logic [ADC_W-1:0] HI = ADC_W'(HI_LEVEL);

    logic [ADC_W-1:0] pos, span;
    logic [W2-1:0]    num, den, quo, sq;
    logic [ADC_W-1:0] nrm, nrm2, sel;
    logic [CUR_W-1:0] rng;
    logic [PW-1:0]    prod;

    always_comb begin
        pos  = level - lo_level;
        span = HI - lo_level;
        num  = {pos, {F{1'b0}}};
        den  = {{ADC_W{1'b0}}, span};
        quo  = (den == '0) ? '0 : (num / den);
        nrm  = quo[ADC_W-1:0];
        sq   = {{ADC_W{1'b0}}, nrm} * {{ADC_W{1'b0}}, nrm};
        nrm2 = sq[W2-1:F];
        sel  = (shape == CURVE_QUAD) ? nrm2 : nrm;
        rng  = imax - imin;
        prod = {{ADC_W{1'b0}}, rng} * {{CUR_W{1'b0}}, sel};
        if (level >= HI)
            target = imax;
        else if (level <= lo_level)
            target = imin;
        else
            target = imin + prod[PW-1:F];
    end

endmodule

// File: rtl/dim_off_ctrl.sv
module dim_off_ctrl
    import dimproc_pkg::*;
#(
    parameter int ADC_W = DEF_ADC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             primed,
    input  logic             hold_on,
    input  logic             dto_en,
    input  logic [ADC_W-1:0] level,
    input  logic [ADC_W-1:0] off_level,
    input  logic [ADC_W-1:0] on_level,
    output out_state_e       state_d,
    output out_state_e       state_q
);
    always_comb begin
        state_d = OUT_ON;
        if (dto_en && primed && !hold_on) begin
            if (state_q == OUT_OFF)
                state_d = (level > on_level) ? OUT_ON : OUT_OFF;
            else
                state_d = (level < off_level) ? OUT_OFF : OUT_ON;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= OUT_ON;
        else     state_q <= state_d;
    end

    assert_off_cause_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == OUT_OFF && $past(state_q) == OUT_ON) |-> $past(level < off_level));

    assert_on_cause_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == OUT_ON && $past(state_q) == OUT_OFF && $past(dto_en && !hold_on))
            |-> $past(level > on_level));

    assert_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        !dto_en |=> (state_q == OUT_ON));

endmodule

// File: rtl/dimproc_top.sv
module dimproc_top
    import dimproc_pkg::*;
#(
    parameter int ADC_W      = DEF_ADC_W,
    parameter int CUR_W      = DEF_CUR_W,
    parameter int FILT_SHIFT = DEF_FILT_SHIFT,
    parameter int HI_LEVEL   = DEF_HI_LEVEL,
    parameter int UART_LEVEL = DEF_UART_LEVEL,
    parameter int UART_RUN   = DEF_UART_RUN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [ADC_W-1:0] smp_code,
    input  logic [ADC_W-1:0] cfg_lo_level,
    input  logic [CUR_W-1:0] cfg_imin,
    input  logic [CUR_W-1:0] cfg_imax,
    input  logic             cfg_quad,
    input  logic             cfg_dto_en,
    input  logic [ADC_W-1:0] cfg_off_level,
    input  logic [ADC_W-1:0] cfg_on_level,
    output logic [CUR_W-1:0] target_o,
    output logic             off_o,
    output logic             uart_o
);
    logic [ADC_W-1:0] filt;
    logic             primed;
    logic             uart_q;
    logic [CUR_W-1:0] curve_tgt;
    out_state_e       st_d, st_q;
    curve_e           shape;

    assign shape = curve_e'(cfg_quad);

    dim_filter #(.ADC_W(ADC_W), .SHIFT(FILT_SHIFT)) u_filt (
        .clk(clk), .rst(rst), .in_valid(smp_valid), .in_code(smp_code),
        .filt_q(filt), .primed_q(primed)
    );

    dim_uart_detect #(.ADC_W(ADC_W), .UART_LEVEL(UART_LEVEL), .UART_RUN(UART_RUN)) u_uart (
        .clk(clk), .rst(rst), .in_valid(smp_valid), .in_code(smp_code), .uart_q(uart_q)
    );

    dim_curve #(.ADC_W(ADC_W), .CUR_W(CUR_W), .HI_LEVEL(HI_LEVEL)) u_curve (
        .level(filt), .lo_level(cfg_lo_level), .imin(cfg_imin), .imax(cfg_imax),
        .shape(shape), .target(curve_tgt)
    );

    dim_off_ctrl #(.ADC_W(ADC_W)) u_off (
        .clk(clk), .rst(rst), .primed(primed), .hold_on(uart_q), .dto_en(cfg_dto_en),
        .level(filt), .off_level(cfg_off_level), .on_level(cfg_on_level),
        .state_d(st_d), .state_q(st_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            target_o <= '0;
        else if (uart_q)
            target_o <= cfg_imax;
        else if (!primed || st_d == OUT_OFF)
            target_o <= '0;
        else
            target_o <= curve_tgt;
    end

    assign off_o  = (st_q == OUT_OFF);
    assign uart_o = uart_q;

    assert_off_zero_R7: assert property (@(posedge clk) disable iff (rst)
        off_o |-> (target_o == '0));

    assert_uart_full_R11: assert property (@(posedge clk) disable iff (rst)
        uart_o |=> (target_o == $past(cfg_imax) && !off_o));

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !primed |-> (target_o == '0));

endmodule

// File: tb/sim_dimproc_top.sv
module sim_dimproc_top;
    localparam int ADC_W = 12;
    localparam int CUR_W = 12;
    localparam int HI    = 2818;
    localparam int ULVL  = 3604;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_valid = 1'b0;
    logic [ADC_W-1:0] smp_code = '0;
    logic [ADC_W-1:0] cfg_lo_level = 12'd400;
    logic [CUR_W-1:0] cfg_imin = 12'd200;
    logic [CUR_W-1:0] cfg_imax = 12'd4000;
    logic             cfg_quad = 1'b0;
    logic             cfg_dto_en = 1'b0;
    logic [ADC_W-1:0] cfg_off_level = 12'd300;
    logic [ADC_W-1:0] cfg_on_level = 12'd500;
    logic [CUR_W-1:0] target_o;
    logic             off_o, uart_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    int m_acc, m_run;
    bit m_primed, m_off, m_uart;

    always #10 clk = ~clk;

    dimproc_top u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_code(smp_code),
        .cfg_lo_level(cfg_lo_level), .cfg_imin(cfg_imin), .cfg_imax(cfg_imax),
        .cfg_quad(cfg_quad), .cfg_dto_en(cfg_dto_en), .cfg_off_level(cfg_off_level),
        .cfg_on_level(cfg_on_level), .target_o(target_o), .off_o(off_o), .uart_o(uart_o)
    );

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            done = 1;
            summary();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mcurve(input int x);
        int lo, n, sel;
        lo = cfg_lo_level;
        if (x >= HI) return cfg_imax;
        if (x <= lo) return cfg_imin;
        n = ((x - lo) << 12) / (HI - lo);
        sel = cfg_quad ? ((n * n) >> 12) : n;
        return cfg_imin + (((cfg_imax - cfg_imin) * sel) >> 12);
    endfunction

    function automatic int mfilt();
        return m_acc >> 4;
    endfunction

    function automatic int mtarget();
        if (m_uart) return cfg_imax;
        if (m_off) return 0;
        return mcurve(mfilt());
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_acc = 0; m_run = 0; m_primed = 0; m_off = 0; m_uart = 0;
        @(negedge clk);
    endtask

    task automatic send(input int x);
        int f;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_code = ADC_W'(x);
        @(negedge clk);
        smp_valid = 1'b0;
        if (!m_primed) m_acc = x << 4;
        else           m_acc = m_acc + x - (m_acc >> 4);
        m_primed = 1;
        if (x > ULVL) begin
            m_run++;
            if (m_run >= 4) m_uart = 1;
        end else m_run = 0;
        f = mfilt();
        if (!cfg_dto_en || m_uart) m_off = 0;
        else if (m_off) m_off = !(f > cfg_on_level);
        else m_off = (f < cfg_off_level);
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        chk({tag, " target"}, target_o, mtarget());
        chk({tag, " off"}, off_o, m_off);
        chk({tag, " uart"}, uart_o, m_uart);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 target", target_o, 0);
        chk("R1 off", off_o, 0);
        chk("R1 uart", uart_o, 0);
        repeat (3) @(negedge clk);
        chk("R1 idle target", target_o, 0);
    endtask

    task automatic t_timing();
        do_reset();
        @(negedge clk);
        smp_valid = 1'b1; smp_code = 12'd3000;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R12 after one edge", target_o, 0);
        @(negedge clk);
        chk("R12 after two edges", target_o, 4000);
        m_acc = 3000 << 4; m_primed = 1;
    endtask

    task automatic t_filter();
        do_reset();
        cfg_lo_level = 12'd0;
        send(1000);
        chk("R2 first load", target_o, mcurve(1000));
        send(2000);
        chk("R2 iir step1 level", mfilt(), 1062);
        check_all("R2 step1");
        send(2000);
        check_all("R2 step2");
        cfg_lo_level = 12'd400;
    endtask

    task automatic t_endpoints();
        do_reset();
        send(100);
        chk("R4 below lo", target_o, 200);
        do_reset();
        send(400);
        chk("R4 at lo", target_o, 200);
        do_reset();
        send(HI);
        chk("R3 at hi", target_o, 4000);
        do_reset();
        send(3300);
        chk("R3 above hi", target_o, 4000);
    endtask

    task automatic t_linear();
        cfg_quad = 1'b0;
        do_reset();
        send(1609);
        chk("R5 midpoint", target_o, 2100);
        do_reset();
        send(900);
        chk("R5 lower part", target_o, mcurve(900));
    endtask

    task automatic t_quad();
        cfg_quad = 1'b1;
        do_reset();
        send(1609);
        chk("R6 midpoint", target_o, 1150);
        do_reset();
        send(2500);
        chk("R6 upper part", target_o, mcurve(2500));
        cfg_quad = 1'b0;
    endtask

    task automatic t_dim_off();
        cfg_dto_en = 1'b1;
        do_reset();
        send(250);
        chk("R7 off flag", off_o, 1);
        chk("R7 target zero", target_o, 0);
        for (int i = 0; i < 90; i++) send(450);
        chk("R8 between thresholds stays off", off_o, 1);
        chk("R8 target still zero", target_o, 0);
        for (int i = 0; i < 90; i++) send(700);
        chk("R8 back on", off_o, 0);
        check_all("R8 after on");
        for (int i = 0; i < 90; i++) send(350);
        chk("R8 between thresholds stays on", off_o, 0);
        check_all("R8 hold on");
    endtask

    task automatic t_dto_disabled();
        cfg_dto_en = 1'b0;
        do_reset();
        send(250);
        chk("R9 no off", off_o, 0);
        chk("R9 curve output", target_o, 200);
        cfg_dto_en = 1'b1;
        send(250);
        chk("R9 enabled now off", off_o, 1);
        cfg_dto_en = 1'b0;
        repeat (2) @(negedge clk);
        m_off = 0;
        chk("R9 cleared on disable", off_o, 0);
    endtask

    task automatic t_uart();
        do_reset();
        send(4000); send(4000); send(4000);
        send(100);
        chk("R10 broken run", uart_o, 0);
        send(4000); send(4000); send(ULVL);
        chk("R10 at level not counted", uart_o, 0);
        send(4000); send(4000); send(4000);
        chk("R10 three only", uart_o, 0);
        send(4000);
        chk("R10 latched", uart_o, 1);
        chk("R10 full current", target_o, 4000);
        cfg_dto_en = 1'b1;
        for (int i = 0; i < 40; i++) send(50);
        chk("R11 sticky", uart_o, 1);
        chk("R11 target held", target_o, 4000);
        chk("R11 no off", off_o, 0);
        cfg_imax = 12'd3500;
        repeat (2) @(negedge clk);
        chk("R11 follows imax", target_o, 3500);
        cfg_imax = 12'd4000;
        cfg_dto_en = 1'b0;
        do_reset();
        chk("R11 reset clears", uart_o, 0);
    endtask

    initial begin
        t_reset();
        t_timing();
        t_filter();
        t_endpoints();
        t_linear();
        t_quad();
        t_dim_off();
        t_dto_disabled();
        t_uart();
        done = 1;
        summary();
    end

endmodule